// File: doc/BRIEF.md
# GPIO Controller with Change Interrupts

This block is a register-mapped controller for a bank of general-purpose pins. The number of pins is a parameter, up to 32. Software reaches it over a plain 32-bit register bus made of a word address, a write strobe, write data and combinational read data. Each pin can be set as an input or as an output. An output pin takes its level from a data register. The write-mask register decides which data bits a write may touch, so that single pins can be set without a read-modify-write.

Every pin is sampled through a two-stage synchroniser. Any transition of the synchronised level, rising or falling, sets a sticky bit for that pin in a change register. Software clears a bit by writing a one to it. A single interrupt line is raised while any change bit is set whose enable bit is also set. Pin multiplexing, pad control and level or single-edge trigger modes are not part of this block.

Top module: `gpio_chg_ctrl`

## Requirements
- R1: After reset every pin is an input (pin_oe all zero), pin_out, the interrupt enables and the change bits are zero, the write mask is all ones, and irq is low.
- R2: Register 0x00 holds the direction. A 1 makes the pin an output and a 0 makes it an input. pin_oe equals this register.
- R3: pin_out follows the data register. A write to offset 0x04 changes only the bits whose bit in the write mask (offset 0x10) is 1.
- R4: A read of offset 0x04 returns the synchronised pin levels. A new level on pin_in is visible there after the second rising clock edge.
- R5: A rising or falling transition on a pin sets that pin's bit in the change register (offset 0x0C) at the third rising clock edge after the input moves.
- R6: Writing 1 to a change bit clears it. Writing 0 leaves it as it was.
- R7: When a new transition and a clearing write hit the same change bit in the same cycle, the bit stays set. Other bits in that write are still cleared.
- R8: irq is high exactly while some bit of (change AND enable) is 1. The enable register is at offset 0x08, and a 1 in it unmasks the pin.
- R9: Offset 0x14 reads all ones on the implemented bits, which means both-edge mode. Writes to it have no effect.
- R10: Register bits at or above the pin count read zero and ignore writes. Offsets outside 0x00 to 0x14 read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | ADDR_W | Byte address of the register word |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pin_in | input | NPINS | Pin levels from the pads |
| pin_out | output | NPINS | Levels driven to the pads |
| pin_oe | output | NPINS | Output enables for the pads |
| irq | output | 1 | Combined change interrupt |

## Verification
The bench builds the block with NPINS set to 12 and ADDR_W left at 5. With 12 pins, the unimplemented upper register bits can be written and read back, so the zero-read and ignored-write behaviour is tested. The five address bits also reach two unmapped word offsets. A pad model in the bench loops pin_out back onto pin_in wherever pin_oe is set. This lets the masked data writes be observed both on the pins and through the synchronised read path, and it lets the bench place an edge on exactly the cycle of a clearing write.

// File: rtl/gpio_chg_pkg.sv
// Shared constants and types for the GPIO change-interrupt controller.
// Assumes a 32-bit bus and word-aligned register offsets.
package gpio_chg_pkg;
    localparam int BUS_W   = 32;
    localparam int IDX_LSB = 2;   // byte address to word index
    localparam int IDX_W   = 3;
    localparam int NREG    = 6;

    typedef enum logic [IDX_W-1:0] {
        SEL_DIR  = 3'd0,
        SEL_DATA = 3'd1,
        SEL_IEN  = 3'd2,
        SEL_CHG  = 3'd3,
        SEL_WMSK = 3'd4,
        SEL_TYPE = 3'd5
    } reg_sel_e;
endpackage

// File: rtl/gpio_bus_decode.sv
// Turns the bus address into a register select and write strobes.
// Assumes ADDR_W >= 5; address bits above the word index must be zero to hit.
module gpio_bus_decode
    import gpio_chg_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    output reg_sel_e          sel,
    output logic              hit,
    output logic [NREG-1:0]   wr_stb
);
    localparam int TOP_IDX = IDX_LSB + IDX_W;

    logic upper_zero;
    logic [IDX_W-1:0] idx;

    // Check that the address bits above the word index are clear.
    generate
        if (ADDR_W > TOP_IDX) begin : g_upper
            assign upper_zero = (addr[ADDR_W-1:TOP_IDX] == '0);
        end else begin : g_noupper
            assign upper_zero = 1'b1;
        end
    endgenerate

    assign idx = addr[TOP_IDX-1:IDX_LSB];

    // Decode the word index into a select and one write strobe per register.
    always_comb begin
        sel    = reg_sel_e'(idx);
        hit    = upper_zero && (int'(idx) < NREG);
        wr_stb = '0;
        if (hit && we) begin
            wr_stb[idx] = 1'b1;
        end
    end
endmodule

// File: rtl/gpio_pin_sync.sv
// Two-flop synchroniser per pin plus a stage that holds the previous level.
// A change pulse is high for one cycle after the synchronised level moves.
// Assumes pins are steady during reset (all stages reset to zero).
module gpio_pin_sync #(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_in,
    output logic [NPINS-1:0] level,
    output logic [NPINS-1:0] chg_pulse
);
    logic [NPINS-1:0] meta_q, sync_q, prev_q;

    // Shift the pin levels through the synchroniser and the history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pin_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign level     = sync_q;
    assign chg_pulse = sync_q ^ prev_q;
endmodule

// File: rtl/gpio_chg_latch.sv
// Sticky per-pin change bits. A bit is set by a change pulse and cleared
// by a write of one. A pulse in the same cycle beats the clear.
module gpio_chg_latch #(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] chg_pulse,
    input  logic             clr_we,
    input  logic [NPINS-1:0] clr_bits,
    output logic [NPINS-1:0] chg_q
);
    logic [NPINS-1:0] clr_eff;

    assign clr_eff = clr_we ? clr_bits : '0;

    // Update the change bits, with setting taking priority over clearing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chg_q <= '0;
        end else begin
            chg_q <= (chg_q & ~clr_eff) | chg_pulse;
        end
    end

    AST_PULSE_SETS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_pulse != '0) |=> ((chg_q & $past(chg_pulse)) == $past(chg_pulse))); // R5
    AST_CLEAR_DROPS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_eff & ~chg_pulse) != '0) |=> ((chg_q & $past(clr_eff & ~chg_pulse)) == '0)); // R6
    AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((chg_q & ~$past(chg_q) & ~$past(chg_pulse)) == '0)); // R5
    AST_EDGE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_eff & chg_pulse) != '0) |=> ((chg_q & $past(clr_eff & chg_pulse)) != '0)); // R7
endmodule

// File: rtl/gpio_chg_ctrl.sv
// GPIO controller top: register file, masked data writes, read mux and
// the combined change interrupt. Assumes NPINS is between 1 and 32 and
// that bus writes last one cycle.
module gpio_chg_ctrl
    import gpio_chg_pkg::*;
#(
    parameter int NPINS  = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic              irq
);
    localparam logic [NPINS-1:0] TYPE_BOTH = '1;

    reg_sel_e         sel;
    logic             hit;
    logic [NREG-1:0]  wr_stb;
    logic [NPINS-1:0] wd_n;
    logic [NPINS-1:0] dir_q, dout_q, ien_q, wmsk_q;
    logic [NPINS-1:0] level, chg_pulse, chg_q;
    logic [NPINS-1:0] rd_n;

    assign wd_n = bus_wdata[NPINS-1:0];

    gpio_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr   (bus_addr),
        .we     (bus_we),
        .sel    (sel),
        .hit    (hit),
        .wr_stb (wr_stb)
    );

    gpio_pin_sync #(.NPINS(NPINS)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_in    (pin_in),
        .level     (level),
        .chg_pulse (chg_pulse)
    );

    gpio_chg_latch #(.NPINS(NPINS)) u_chg (
        .clk       (clk),
        .rst_n     (rst_n),
        .chg_pulse (chg_pulse),
        .clr_we    (wr_stb[SEL_CHG]),
        .clr_bits  (wd_n),
        .chg_q     (chg_q)
    );

    // Hold the direction, enable and write-mask registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q  <= '0;
            ien_q  <= '0;
            wmsk_q <= '1;
        end else begin
            if (wr_stb[SEL_DIR])  dir_q  <= wd_n;
            if (wr_stb[SEL_IEN])  ien_q  <= wd_n;
            if (wr_stb[SEL_WMSK]) wmsk_q <= wd_n;
        end
    end

    // Update the output data register only where the write mask allows it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_q <= '0;
        end else if (wr_stb[SEL_DATA]) begin
            dout_q <= (dout_q & ~wmsk_q) | (wd_n & wmsk_q);
        end
    end

    // Select the read word; the data offset returns the synchronised pins.
    always_comb begin
        rd_n = '0;
        if (hit) begin
            unique case (sel)
                SEL_DIR:  rd_n = dir_q;
                SEL_DATA: rd_n = level;
                SEL_IEN:  rd_n = ien_q;
                SEL_CHG:  rd_n = chg_q;
                SEL_WMSK: rd_n = wmsk_q;
                SEL_TYPE: rd_n = TYPE_BOTH;
                default:  rd_n = '0;
            endcase
        end
    end

    assign bus_rdata = 32'(rd_n);
    assign pin_out   = dout_q;
    assign pin_oe    = dir_q;
    assign irq       = |(chg_q & ien_q);

    AST_ONE_WRITE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_stb)); // R10
    AST_MASKED_DATA_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb[SEL_DATA] |=> (((pin_out ^ $past(pin_out)) & ~$past(wmsk_q)) == '0)); // R3
    AST_OUT_STABLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb[SEL_DATA] |=> $stable(pin_out)); // R3
    AST_IRQ_FOLLOWS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_q == '0) |-> !irq); // R8

    generate
        if (NPINS < 32) begin : g_upper_chk
            AST_UPPER_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
                bus_rdata[31:NPINS] == '0); // R10
        end
    endgenerate
endmodule

// File: tb/gpio_chg_ctrl_tb.sv
module gpio_chg_ctrl_tb;
    localparam int NP = 12;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_we = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pin_in, pin_out, pin_oe, ext;
    logic          irq;
    int            errors = 0;
    int            checks = 0;
    bit            done = 1'b0;

    always #5 clk = ~clk;

    // pad model: driven pins loop back, others come from ext
    assign pin_in = (pin_oe & pin_out) | (~pin_oe & ext);

    gpio_chg_ctrl #(.NPINS(NP), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    typedef struct packed {
        logic [4:0]  a;
        logic [31:0] w;
        logic [31:0] e;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VEC [NV] = '{
        '{5'h00, 32'hFFFF_FA5A, 32'h0000_0A5A},  // R2 R10
        '{5'h08, 32'h0000_0F0F, 32'h0000_0F0F},  // R8 enable
        '{5'h10, 32'hFFFF_F0F0, 32'h0000_00F0},  // R3 R10
        '{5'h14, 32'h0000_0000, 32'h0000_0FFF},  // R9
        '{5'h18, 32'hFFFF_FFFF, 32'h0000_0000},  // R10 unmapped
        '{5'h1C, 32'hFFFF_FFFF, 32'h0000_0000},  // R10 unmapped
        '{5'h00, 32'h0000_0000, 32'h0000_0000},
        '{5'h10, 32'hFFFF_FFFF, 32'h0000_0FFF},
        '{5'h08, 32'h0000_0000, 32'h0000_0000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] v);
        bus_we = 1'b0; bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        logic [31:0] v;
        ext = '0;
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);

        // R1 reset state
        chk("R1 pin_oe", 32'(pin_oe), 32'h0);
        chk("R1 pin_out", 32'(pin_out), 32'h0);
        chk("R1 irq", 32'(irq), 32'h0);
        rd(5'h10, v); chk("R1 wmask", v, 32'h0FFF);
        rd(5'h0C, v); chk("R1 change", v, 32'h0);
        rd(5'h08, v); chk("R1 enable", v, 32'h0);

        // register table walk
        for (int i = 0; i < NV; i++) begin
            wr(VEC[i].a, VEC[i].w);
            rd(VEC[i].a, v);
            chk($sformatf("R10 vec%0d readback", i), v, VEC[i].e);
            if (VEC[i].a == 5'h00) chk("R2 pin_oe", 32'(pin_oe), VEC[i].e);
        end

        // R3 masked writes on the pins, R4 readback through the loop
        wr(5'h10, 32'h0F0);
        wr(5'h00, 32'hFFF);
        wr(5'h04, 32'hFFF);
        chk("R3 masked pin_out", 32'(pin_out), 32'h0F0);
        wr(5'h10, 32'hFFF);
        wr(5'h04, 32'h5A5);
        chk("R3 full pin_out", 32'(pin_out), 32'h5A5);
        wait_n(2);
        rd(5'h04, v); chk("R4 data readback", v, 32'h5A5);
        wr(5'h00, 32'h000);
        chk("R2 inputs oe", 32'(pin_oe), 32'h0);
        chk("R3 pin_out held", 32'(pin_out), 32'h5A5);
        wait_n(4);
        wr(5'h0C, 32'hFFF);
        rd(5'h0C, v); chk("R6 clear all", v, 32'h0);

        // R4/R5 rising edge timing on pin 3
        ext[3] = 1'b1;
        wait_n(1);
        rd(5'h04, v); chk("R4 not yet visible", v, 32'h0);
        wait_n(1);
        rd(5'h04, v); chk("R4 visible after two edges", v, 32'h008);
        rd(5'h0C, v); chk("R5 not yet latched", v, 32'h0);
        wait_n(1);
        rd(5'h0C, v); chk("R5 rise latched", v, 32'h008);

        // R8 masking
        wr(5'h08, 32'h004);
        chk("R8 masked irq", 32'(irq), 32'h0);
        wr(5'h08, 32'h008);
        chk("R8 unmasked irq", 32'(irq), 32'h1);

        // R6 write zero keeps, write one clears
        wr(5'h0C, 32'h000);
        rd(5'h0C, v); chk("R6 write zero keeps", v, 32'h008);
        wr(5'h0C, 32'h008);
        rd(5'h0C, v); chk("R6 write one clears", v, 32'h0);
        chk("R8 irq drops", 32'(irq), 32'h0);

        // R5 falling edge
        ext[3] = 1'b0;
        wait_n(3);
        rd(5'h0C, v); chk("R5 fall latched", v, 32'h008);
        chk("R8 irq on fall", 32'(irq), 32'h1);
        wr(5'h0C, 32'h008);

        // R7 edge on pin 6 coincides with clear of pins 5 and 6
        ext[5] = 1'b1;
        wait_n(3);
        rd(5'h0C, v); chk("R7 setup pin5", v, 32'h020);
        ext[6] = 1'b1;
        @(negedge clk);
        wr(5'h0C, 32'h060);
        rd(5'h0C, v); chk("R7 edge beats clear", v, 32'h040);

        // R9 type stays after a write of ones too
        wr(5'h14, 32'hFFFF_FFFF);
        rd(5'h14, v); chk("R9 type constant", v, 32'h0FFF);

        summary();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            summary();
        end
    end
endmodule